// File: doc/BRIEF.md
# Shadowed SRAM Store Controller

This block models a byte-wide static RAM in which every working cell is paired with a nonvolatile shadow cell. A controller copies the whole array in either direction. A copy from working memory into the shadow is a store, and a copy from the shadow back into working memory is a recall. The memory side is a plain asynchronous-style SRAM pin set: active-low chip enable, output enable and write enable, plus an address bus and a byte data bus. All of these are sampled on the block clock. The bus has no valid/ready handshake and no back-pressure. A refused access simply never reaches the array, and a read that is refused shows a disabled output.

A bidirectional active-low handshake line is split into two pins. One is a request input that a system pulls low to ask for a store. The other is an open-drain busy output that the block pulls low while a store runs. A store can start from three sources: a software strobe, a power-fail input, or the handshake request. A dirty flag records whether any write has happened since the last store or recall. The power-fail and handshake triggers are dropped while the array is clean; the software strobe always stores. A recall runs by itself after reset and models power-up.

A store first opens a delay window so that a write cycle already in progress can finish. The parallel copy then happens, and busy is held low for a fixed store time. The block then stays disabled until the request input is released. A saturating counter tracks stores and raises a wear flag at a parameterised limit.

Top module: `nvsram_ctrl`

## Requirements
- R1: A read is served (`dout_en`=1, `dout` = stored byte at `addr`) only when `ce_n`=0, `oe_n`=0, `we_n`=1, `hs_req_n`=1 and no copy is running. The output follows `addr` changes with no control-pin toggling. Otherwise `dout_en`=0 and `dout`=0.
- R2: A write cycle opens on a clock edge where `ce_n` and `we_n` are both 0 and access is allowed. On the first edge where either is 1, the address and data from the last cycle in which both were 0 are committed.
- R3: With `we_n`=0 the output stays disabled, even when `ce_n` and `oe_n` are both 0.
- R4: A `sw_store` pulse always starts a store, dirty or clean. `hs_busy_n` is then 0 for exactly DELAY_CYC+STORE_CYC cycles, starting at the edge that samples the strobe.
- R5: A `pwr_fail` pulse or a low `hs_req_n` starts a store only if a write has been committed since the last store or recall. Otherwise `hs_busy_n` stays 1.
- R6: While a store or recall runs, reads are refused, and a write cycle started after the trigger never reaches the array.
- R7: A write cycle that is open when a store is triggered may still commit during the delay window. Its data is included in the store.
- R8: After a store finishes, all access stays refused until `hs_req_n` is 1.
- R9: After reset, a recall lasting RECALL_CYC cycles copies the shadow into working memory and leaves the array clean. Access is refused during the recall.
- R10: Each store increments a saturating counter. `store_wear` becomes 1 when the count reaches STORE_LIMIT and stays 1 through later stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset (power-up; starts a recall) |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; kept high by the system when idle |
| addr | input | AW | Byte address |
| din | input | DW | Write data |
| dout | output | DW | Read data, zero when disabled |
| dout_en | output | 1 | Output drivers enabled |
| hs_req_n | input | 1 | External pull-down of the handshake line (store request) |
| hs_busy_n | output | 1 | Open-drain busy, 0 while a store is running |
| pwr_fail | input | 1 | Supply-loss detect, requests an automatic store |
| sw_store | input | 1 | Software store strobe |
| store_wear | output | 1 | Store count has reached STORE_LIMIT |

## Verification
Some properties are checked on every cycle. The output is never enabled while busy is low. No write commits outside idle or the delay window. The dirty flag is clear while a store copies. Busy is released only into the hold state. A clean array never reacts to power-fail or the handshake. The hold state persists while the request stays low. The wear flag never drops. Data-level results can only be shown by the bench scenarios: a pending write landing in the stored image, a blocked write leaving old data, the exact busy length, and a recall restoring the shadow after reset.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [2:0] {
    ST_RECALL = 3'd0,
    ST_IDLE   = 3'd1,
    ST_DELAY  = 3'd2,
    ST_STORE  = 3'd3,
    ST_HOLD   = 3'd4
  } nvs_state_e;
endpackage

// File: rtl/nvs_array.sv
module nvs_array #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic          do_store,
  input  logic          do_recall,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DEPTH*DW-1:0] work_flat;

  // one working byte paired with one shadow byte per location
  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic [DW-1:0] word;
    logic [DW-1:0] shadow;

    always_ff @(posedge clk) begin
      if (do_recall) word <= shadow;
      else if (wr_en && wa == AW'(g)) word <= wd;
    end

    always_ff @(posedge clk) begin
      if (do_store) shadow <= word;
    end

    assign work_flat[g*DW +: DW] = word;
  end

  assign rdata = work_flat[raddr*DW +: DW];
endmodule

// File: rtl/nvs_access.sv
module nvs_access
  import nvs_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  input  logic          hs_req_n,
  input  nvs_state_e    st,
  input  logic          tmr_zero,
  output logic          rd_en,
  output logic          wr_commit,
  output logic [AW-1:0] wa,
  output logic [DW-1:0] wd
);
  logic wr_open;
  logic allow_new;
  logic commit_ok;
  logic both_low;

  // new cycles need idle state and a released handshake line
  assign allow_new = (st == ST_IDLE) && hs_req_n;
  // an open write may finish in idle or before the last delay cycle
  assign commit_ok = (st == ST_IDLE) || (st == ST_DELAY && !tmr_zero);
  assign both_low  = !ce_n && !we_n;

  assign rd_en     = allow_new && !ce_n && !oe_n && we_n;
  assign wr_commit = wr_open && !both_low && commit_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_open <= 1'b0;
      wa      <= '0;
      wd      <= '0;
    end else if (both_low && (wr_open ? commit_ok : allow_new)) begin
      wr_open <= 1'b1;
      wa      <= addr;
      wd      <= din;
    end else begin
      wr_open <= 1'b0;
    end
  end
endmodule

// File: rtl/nvs_seq.sv
module nvs_seq
  import nvs_pkg::*;
#(
  parameter int DELAY_CYC   = 3,
  parameter int STORE_CYC   = 5,
  parameter int RECALL_CYC  = 4,
  parameter int STORE_LIMIT = 200000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_store,
  input  logic       pwr_fail,
  input  logic       hs_req_n,
  input  logic       wr_commit,
  output nvs_state_e st,
  output logic       tmr_zero,
  output logic       dirty,
  output logic       do_store,
  output logic       do_recall,
  output logic       wear
);
  localparam int MAXC = (DELAY_CYC > STORE_CYC)
                        ? ((DELAY_CYC > RECALL_CYC) ? DELAY_CYC : RECALL_CYC)
                        : ((STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC);
  localparam int TW = $clog2(MAXC + 1);
  localparam int CW = $clog2(STORE_LIMIT + 1);

  logic [TW-1:0] tmr;
  logic [CW-1:0] cnt;
  logic          trigger;

  assign tmr_zero  = (tmr == '0);
  assign trigger   = sw_store || (dirty && (pwr_fail || !hs_req_n));
  assign do_store  = (st == ST_DELAY) && tmr_zero;
  assign do_recall = (st == ST_RECALL) && tmr_zero;
  assign wear      = (cnt == CW'(STORE_LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_RECALL;
      tmr <= TW'(RECALL_CYC - 1);
    end else begin
      unique case (st)
        ST_RECALL: if (tmr_zero) st <= ST_IDLE; else tmr <= tmr - 1'b1;
        ST_IDLE: if (trigger) begin
          st  <= ST_DELAY;
          tmr <= TW'(DELAY_CYC - 1);
        end
        ST_DELAY: if (tmr_zero) begin
          st  <= ST_STORE;
          tmr <= TW'(STORE_CYC - 1);
        end else tmr <= tmr - 1'b1;
        ST_STORE: if (tmr_zero) st <= ST_HOLD; else tmr <= tmr - 1'b1;
        ST_HOLD: if (hs_req_n) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dirty <= 1'b0;
      cnt   <= '0;
    end else begin
      if (do_store || do_recall) dirty <= 1'b0;
      else if (wr_commit) dirty <= 1'b1;
      if (do_store && !wear) cnt <= cnt + 1'b1;
    end
  end

  AST_HOLD_UNTIL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HOLD && !hs_req_n) |=> (st == ST_HOLD)); // R8
  AST_WEAR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wear |=> wear); // R10
  AST_CLEAN_DURING_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STORE) |-> !dirty); // R6
endmodule

// File: rtl/nvsram_ctrl.sv
module nvsram_ctrl
  import nvs_pkg::*;
#(
  parameter int AW          = 4,
  parameter int DW          = 8,
  parameter int DELAY_CYC   = 3,
  parameter int STORE_CYC   = 5,
  parameter int RECALL_CYC  = 4,
  parameter int STORE_LIMIT = 200000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_en,
  input  logic          hs_req_n,
  output logic          hs_busy_n,
  input  logic          pwr_fail,
  input  logic          sw_store,
  output logic          store_wear
);
  nvs_state_e    st;
  logic          tmr_zero, dirty, do_store, do_recall;
  logic          rd_en, wr_commit;
  logic [AW-1:0] wa;
  logic [DW-1:0] wd, rdata;

  nvs_seq #(
    .DELAY_CYC(DELAY_CYC), .STORE_CYC(STORE_CYC),
    .RECALL_CYC(RECALL_CYC), .STORE_LIMIT(STORE_LIMIT)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .sw_store(sw_store), .pwr_fail(pwr_fail),
    .hs_req_n(hs_req_n), .wr_commit(wr_commit), .st(st), .tmr_zero(tmr_zero),
    .dirty(dirty), .do_store(do_store), .do_recall(do_recall), .wear(store_wear)
  );

  nvs_access #(.AW(AW), .DW(DW)) u_acc (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .hs_req_n(hs_req_n), .st(st), .tmr_zero(tmr_zero),
    .rd_en(rd_en), .wr_commit(wr_commit), .wa(wa), .wd(wd)
  );

  nvs_array #(.AW(AW), .DW(DW)) u_arr (
    .clk(clk), .wr_en(wr_commit), .wa(wa), .wd(wd), .do_store(do_store),
    .do_recall(do_recall), .raddr(addr), .rdata(rdata)
  );

  assign dout_en   = rd_en;
  assign dout      = rd_en ? rdata : '0;
  assign hs_busy_n = !(st == ST_DELAY || st == ST_STORE);

  AST_NO_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_busy_n |-> !dout_en); // R6
  AST_COMMIT_OUTSIDE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> (!do_store && (st == ST_IDLE || st == ST_DELAY))); // R7
  AST_BUSY_ENDS_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_busy_n) |-> (st == ST_HOLD)); // R4
  AST_CLEAN_NO_HW_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && !dirty && !sw_store) |=> hs_busy_n); // R5
endmodule

// File: tb/nvsram_ctrl_tb.sv
module nvsram_ctrl_tb;
  localparam int AW = 4, DW = 8;
  localparam int DLY = 3, STC = 5, RCC = 4, LIM = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_en, hs_busy_n, store_wear;
  logic hs_req_n = 1'b1, pwr_fail = 1'b0, sw_store = 1'b0;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  nvsram_ctrl #(.AW(AW), .DW(DW), .DELAY_CYC(DLY), .STORE_CYC(STC),
                .RECALL_CYC(RCC), .STORE_LIMIT(LIM)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
    .hs_req_n(hs_req_n), .hs_busy_n(hs_busy_n), .pwr_fail(pwr_fail),
    .sw_store(sw_store), .store_wear(store_wear)
  );

  // vector: {is_write, addr, wdata, expected read}
  localparam logic [20:0] VEC [10] = '{
    {1'b1, 4'h1, 8'hA5, 8'h00}, {1'b1, 4'h2, 8'h3C, 8'h00},
    {1'b1, 4'hF, 8'h81, 8'h00}, {1'b1, 4'h0, 8'hFF, 8'h00},
    {1'b1, 4'h1, 8'h7E, 8'h00}, {1'b0, 4'h1, 8'h00, 8'h7E},
    {1'b0, 4'h2, 8'h00, 8'h3C}, {1'b0, 4'hF, 8'h00, 8'h81},
    {1'b0, 4'h0, 8'h00, 8'hFF}, {1'b0, 4'h2, 8'h00, 8'h3C}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk); addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_rd(logic [AW-1:0] a, output logic en, output logic [DW-1:0] d);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
    #2; en = dout_en; d = dout;
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic wait_busy_done();
    for (int i = 0; i < 40 && !hs_busy_n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
    end
  end

  initial begin
    logic en; logic [DW-1:0] d; int lowc; bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9: reset state, recall blocks access
    addr = 4'h1; ce_n = 1'b0; oe_n = 1'b0; #2;
    chk("R9 read refused during recall", dout_en, 0);
    chk("R9 busy idle after reset", hs_busy_n, 1);
    chk("R10 wear clear after reset", store_wear, 0);
    ce_n = 1'b1; oe_n = 1'b1;
    repeat (RCC + 2) @(negedge clk);

    // R1 R2 table walk
    foreach (VEC[i]) begin
      if (VEC[i][20]) do_wr(VEC[i][19:16], VEC[i][15:8]);
      else begin
        do_rd(VEC[i][19:16], en, d);
        chk("R1 read enabled", en, 1);
        chk("R2 read data", d, VEC[i][7:0]);
      end
    end
    // R1: address follows with no control toggle
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; addr = 4'h2; #2;
    chk("R1 follow addr 2", dout, 8'h3C);
    addr = 4'hF; #2;
    chk("R1 follow addr F", dout, 8'h81);
    oe_n = 1'b1; #1;
    chk("R1 oe high disables", {dout_en, dout}, 0);
    // R3: we low mutes output
    we_n = 1'b0; oe_n = 1'b0; addr = 4'h4; din = 8'h5A; #1;
    chk("R3 we low mutes output", dout_en, 0);
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    do_rd(4'h4, en, d);
    chk("R2 write committed on we rise", d, 8'h5A);

    // R4: software store, exact busy length
    @(negedge clk); sw_store = 1'b1;
    @(negedge clk); sw_store = 1'b0;
    lowc = 0;
    for (int i = 0; i < 30; i++) begin
      if (!hs_busy_n) lowc++;
      @(negedge clk);
    end
    chk("R4 busy length", lowc, DLY + STC);

    // R5: clean array ignores power fail and handshake
    @(negedge clk); pwr_fail = 1'b1;
    @(negedge clk); pwr_fail = 1'b0;
    seen = 0;
    for (int i = 0; i < 12; i++) begin
      if (!hs_busy_n) seen = 1;
      @(negedge clk);
    end
    chk("R5 clean pwr_fail no store", seen, 0);
    @(negedge clk); hs_req_n = 1'b0;
    seen = 0;
    for (int i = 0; i < 6; i++) begin
      if (!hs_busy_n) seen = 1;
      @(negedge clk);
    end
    chk("R5 clean handshake no store", seen, 0);
    do_rd(4'h2, en, d);
    chk("R1 read refused while line low", en, 0);
    hs_req_n = 1'b1;
    @(negedge clk);

    // R5: dirty array stores on power fail
    do_wr(4'h3, 8'h11);
    @(negedge clk); pwr_fail = 1'b1;
    @(negedge clk); pwr_fail = 1'b0;
    chk("R5 dirty pwr_fail stores", hs_busy_n, 0);
    wait_busy_done();
    repeat (2) @(negedge clk);
    chk("R10 wear clear below limit", store_wear, 0);

    // R7 R6 R8: handshake store with write in flight
    do_wr(4'h3, 8'h22);
    @(negedge clk); addr = 4'h5; din = 8'hC3; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); hs_req_n = 1'b0;
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
    @(negedge clk); addr = 4'h2; din = 8'h99; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
    chk("R6 busy during store", hs_busy_n, 0);
    wait_busy_done();
    repeat (3) @(negedge clk);
    do_rd(4'h5, en, d);
    chk("R8 refused until line released", en, 0);
    hs_req_n = 1'b1;
    repeat (2) @(negedge clk);
    do_rd(4'h5, en, d);
    chk("R7 pending write landed", d, 8'hC3);
    do_rd(4'h2, en, d);
    chk("R6 late write blocked", d, 8'h3C);
    chk("R10 wear at limit", store_wear, 1);
    @(negedge clk); sw_store = 1'b1;
    @(negedge clk); sw_store = 1'b0;
    wait_busy_done();
    repeat (2) @(negedge clk);
    chk("R10 wear stays set", store_wear, 1);

    // R9: recall after reset restores shadow, array clean
    do_wr(4'h5, 8'h44);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    repeat (RCC + 2) @(negedge clk);
    do_rd(4'h5, en, d);
    chk("R9 recall restores shadow", d, 8'hC3);
    @(negedge clk); pwr_fail = 1'b1;
    @(negedge clk); pwr_fail = 1'b0;
    seen = 0;
    for (int i = 0; i < 6; i++) begin
      if (!hs_busy_n) seen = 1;
      @(negedge clk);
    end
    chk("R9 clean after recall", seen, 0);

    done = 1'b1;
    finish_run();
  end
endmodule